// File: doc/BRIEF.md
# Nonvolatile Wiper Register Controller

This block keeps a potentiometer wiper setting in a 5-bit working register that drives the wiper output directly. Next to it sits a persistent copy that models a nonvolatile cell. A decoded command arrives with a 2-bit operation code and a 5-bit data field. It can load the working register, load the persistent copy, copy persistent to working, or copy working to persistent. The serial bus that decodes the commands and the resistor ladder that the wiper code drives are outside this block.

A write into the persistent copy is slow. It takes a timed store interval, `STORE_CYCLES` clocks long, and the value is committed only when the interval ends. After any reset a recall sequence runs for `INIT_CYCLES` clocks and then loads the working register from the persistent copy. The persistent copy survives the soft reset `rst_n` and is cleared only by the cold reset `cold_rst_n`.

The command input follows valid/ready rules. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole recall and store intervals. The block never stalls a command: a command offered while `cmd_ready` is low is discarded and raises the sticky flag `cmd_dropped`. A producer that needs every command applied must therefore wait for `cmd_ready` before raising `cmd_valid`.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: After a cold reset and the recall that follows it, the wiper output is 0, because the persistent copy holds 0 from a cold reset.
- R2: An accepted command with op code 0 loads `cmd_data` into the working register, and the wiper output shows it from the next clock. This holds for the whole range 0 to 31.
- R3: An accepted command with op code 1 stores `cmd_data` into the persistent copy and leaves the wiper output unchanged.
- R4: An accepted command with op code 2 copies the persistent copy into the working register, and the wiper output shows it from the next clock.
- R5: An accepted command with op code 3 stores the current working value into the persistent copy.
- R6: After either reset is released, `init_busy` is high for exactly `INIT_CYCLES` clocks and the wiper output is 0 during that time. On the clock where `init_busy` falls, the wiper takes the persistent value.
- R7: Op codes 1 and 3 start a store. `store_busy` is high for exactly `STORE_CYCLES` clocks starting on the clock after acceptance. The persistent copy changes only when that interval ends.
- R8: A command offered while `cmd_ready` is low has no effect on the wiper or on the persistent copy, and it sets `cmd_dropped`. `cmd_dropped` stays high until a reset.
- R9: A soft reset keeps the persistent copy, and the recall restores it to the wiper. A cold reset clears the persistent copy to 0.
- R10: A soft reset during a store aborts it, and the persistent copy keeps its earlier value.
- R11: `cmd_ready` is high exactly when neither `init_busy` nor `store_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, asynchronous; keeps the persistent copy |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous; also clears the persistent copy |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | Operation: 0 write working, 1 write persistent, 2 persistent to working, 3 working to persistent |
| cmd_data | input | WIPER_W | Wiper code for op codes 0 and 1 |
| cmd_ready | output | 1 | Command is taken on this edge if valid |
| wiper | output | WIPER_W | Current wiper code |
| init_busy | output | 1 | Recall sequence running |
| store_busy | output | 1 | Store interval running |
| cmd_dropped | output | 1 | Sticky: a command was offered while not ready |

## Verification
The properties assume that `cmd_op` and `cmd_data` hold known values whenever `cmd_valid` is high. They also assume that both resets change only away from the clock edge. The stimulus applies every input shortly after a falling edge and holds a command for exactly one clock. It offers commands both when the block is ready and when it is not, on purpose, so that both the accept path and the drop path are driven. The recall and store lengths are shortened through parameters so that both intervals expire many times within the run.

// File: rtl/wnv_pkg.sv
package wnv_pkg;
  typedef enum logic [1:0] {
    OP_WR_WORK  = 2'd0,
    OP_WR_KEEP  = 2'd1,
    OP_KEEP2WRK = 2'd2,
    OP_WRK2KEEP = 2'd3
  } wnv_op_e;
endpackage

// File: rtl/wnv_countdown.sv
module wnv_countdown #(
  parameter int CYCLES     = 4,
  parameter bit START_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] rst_val;

  generate
    if (START_FULL) begin : g_full
      assign rst_val = FULL;
    end else begin : g_empty
      assign rst_val = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= rst_val;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end else if (load) begin
      cnt <= FULL;
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == ONE);
endmodule

// File: rtl/wnv_cmd_gate.sv
module wnv_cmd_gate
  import wnv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       init_busy,
  input  logic       store_busy,
  output logic       cmd_ready,
  output logic       acc_wr_work,
  output logic       acc_wr_keep,
  output logic       acc_keep2wrk,
  output logic       acc_wrk2keep,
  output logic       dropped
);
  logic    take;
  wnv_op_e op;

  assign op        = wnv_op_e'(cmd_op);
  assign cmd_ready = !(init_busy || store_busy);
  assign take      = cmd_valid && cmd_ready;

  always_comb begin
    acc_wr_work  = 1'b0;
    acc_wr_keep  = 1'b0;
    acc_keep2wrk = 1'b0;
    acc_wrk2keep = 1'b0;
    if (take) begin
      unique case (op)
        OP_WR_WORK:  acc_wr_work  = 1'b1;
        OP_WR_KEEP:  acc_wr_keep  = 1'b1;
        OP_KEEP2WRK: acc_keep2wrk = 1'b1;
        OP_WRK2KEEP: acc_wrk2keep = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dropped <= 1'b0;
    end else if (cmd_valid && !cmd_ready) begin
      dropped <= 1'b1;
    end
  end
endmodule

// File: rtl/wnv_regs.sv
module wnv_regs #(
  parameter int WIPER_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cold_rst_n,
  input  logic               wr_work,
  input  logic               wr_keep,
  input  logic               keep2wrk,
  input  logic               wrk2keep,
  input  logic               recall_done,
  input  logic               store_done,
  input  logic [WIPER_W-1:0] data,
  output logic [WIPER_W-1:0] work
);
  logic [WIPER_W-1:0] keep;
  logic [WIPER_W-1:0] pend;

  // working register: lost on either reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
    end else if (recall_done || keep2wrk) begin
      work <= keep;
    end else if (wr_work) begin
      work <= data;
    end
  end

  // value waiting for the end of the store interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (wr_keep) begin
      pend <= data;
    end else if (wrk2keep) begin
      pend <= work;
    end
  end

  // persistent copy: cleared only by the cold reset
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      keep <= '0;
    end else if (store_done && rst_n) begin
      keep <= pend;
    end
  end
endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl #(
  parameter int WIPER_W      = 5,
  parameter int INIT_CYCLES  = 1000,
  parameter int STORE_CYCLES = 600000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cold_rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [WIPER_W-1:0] cmd_data,
  output logic               cmd_ready,
  output logic [WIPER_W-1:0] wiper,
  output logic               init_busy,
  output logic               store_busy,
  output logic               cmd_dropped
);
  logic rst_all_n;
  logic acc_wr_work, acc_wr_keep, acc_keep2wrk, acc_wrk2keep;
  logic recall_done, store_done;

  assign rst_all_n = rst_n & cold_rst_n;

  wnv_cmd_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_all_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .init_busy   (init_busy),
    .store_busy  (store_busy),
    .cmd_ready   (cmd_ready),
    .acc_wr_work (acc_wr_work),
    .acc_wr_keep (acc_wr_keep),
    .acc_keep2wrk(acc_keep2wrk),
    .acc_wrk2keep(acc_wrk2keep),
    .dropped     (cmd_dropped)
  );

  wnv_countdown #(.CYCLES(INIT_CYCLES), .START_FULL(1'b1)) u_recall (
    .clk  (clk),
    .rst_n(rst_all_n),
    .load (1'b0),
    .busy (init_busy),
    .done (recall_done)
  );

  wnv_countdown #(.CYCLES(STORE_CYCLES), .START_FULL(1'b0)) u_store (
    .clk  (clk),
    .rst_n(rst_all_n),
    .load (acc_wr_keep || acc_wrk2keep),
    .busy (store_busy),
    .done (store_done)
  );

  wnv_regs #(.WIPER_W(WIPER_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_all_n),
    .cold_rst_n (cold_rst_n),
    .wr_work    (acc_wr_work),
    .wr_keep    (acc_wr_keep),
    .keep2wrk   (acc_keep2wrk),
    .wrk2keep   (acc_wrk2keep),
    .recall_done(recall_done),
    .store_done (store_done),
    .data       (cmd_data),
    .work       (wiper)
  );
endmodule

// File: rtl/wiper_nv_ctrl_chk.sv
module wiper_nv_ctrl_chk #(
  parameter int WIPER_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cold_rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [WIPER_W-1:0] cmd_data,
  input logic               cmd_ready,
  input logic [WIPER_W-1:0] wiper,
  input logic               init_busy,
  input logic               store_busy,
  input logic               cmd_dropped
);
  // R2
  work_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd0) |=> wiper == $past(cmd_data));

  // R3
  keep_write_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd1) |=> (wiper == $past(wiper)) && store_busy);

  // R6
  recall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    init_busy |-> wiper == '0);

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_dropped);

  // R8
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    cmd_dropped |=> cmd_dropped);

  // R8
  dropped_keeps_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (cmd_valid && !cmd_ready && !init_busy) |=> $stable(wiper));

  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (store_busy || init_busy) |-> !cmd_ready);
endmodule

bind wiper_nv_ctrl wiper_nv_ctrl_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cold_rst_n (cold_rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_data   (cmd_data),
  .cmd_ready  (cmd_ready),
  .wiper      (wiper),
  .init_busy  (init_busy),
  .store_busy (store_busy),
  .cmd_dropped(cmd_dropped)
);

// File: tb/wiper_nv_ctrl_test.sv
module wiper_nv_ctrl_test;
  localparam int W     = 5;
  localparam int INIT  = 8;
  localparam int STORE = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cold_rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'd0;
  logic [W-1:0] cmd_data = '0;
  logic         cmd_ready;
  logic [W-1:0] wiper;
  logic         init_busy, store_busy, cmd_dropped;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_work = 0, m_keep = 0, m_pend = 0;
  int m_init = INIT, m_store = 0;
  bit m_drop = 1'b0;

  always #10 clk = ~clk;

  wiper_nv_ctrl #(.WIPER_W(W), .INIT_CYCLES(INIT), .STORE_CYCLES(STORE)) uut (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .wiper(wiper), .init_busy(init_busy),
    .store_busy(store_busy), .cmd_dropped(cmd_dropped)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit rdy;
    if (!cold_rst_n) m_keep = 0;
    if (!cold_rst_n || !rst_n) begin
      m_work = 0; m_pend = 0; m_init = INIT; m_store = 0; m_drop = 0;
    end else begin
      rdy = (m_init == 0) && (m_store == 0);
      if (m_init > 0) begin
        m_init--;
        if (m_init == 0) m_work = m_keep;
      end
      if (m_store > 0) begin
        m_store--;
        if (m_store == 0) m_keep = m_pend;
      end
      if (cmd_valid) begin
        if (!rdy) m_drop = 1;
        else begin
          case (cmd_op)
            2'd0: m_work = cmd_data;
            2'd1: begin m_pend = cmd_data; m_store = STORE; end
            2'd2: m_work = m_keep;
            default: begin m_pend = m_work; m_store = STORE; end
          endcase
        end
      end
    end
    started = 1'b1;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (started && !finished) begin
      check("R2 wiper", wiper, m_init > 0 ? 0 : m_work);
      check("R6 init_busy", init_busy, m_init > 0);
      check("R7 store_busy", store_busy, m_store > 0);
      check("R11 cmd_ready", cmd_ready, (m_init == 0) && (m_store == 0));
      check("R8 cmd_dropped", cmd_dropped, m_drop);
    end
    if (cycles > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic issue(input logic [1:0] op, input int d);
    step(1);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = W'(d);
    step(1);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    step(1);
    while (!cmd_ready) step(1);
  endtask

  initial begin
    step(3);
    cold_rst_n = 1'b1; rst_n = 1'b1;
    // R6: recall length
    step(INIT - 1);
    check("R6 busy before end", init_busy, 1);
    step(1);
    check("R6 busy after end", init_busy, 0);
    // R1: factory value
    check("R1 wiper after cold", wiper, 0);
    // R2: both extremes
    issue(2'd0, 31);
    check("R2 write 31", wiper, 31);
    issue(2'd0, 0);
    check("R2 write 0", wiper, 0);
    issue(2'd0, 12);
    // R3: persistent write leaves wiper
    issue(2'd1, 5);
    check("R3 wiper held", wiper, 12);
    check("R7 store busy", store_busy, 1);
    // R8: dropped while storing
    issue(2'd0, 7);
    check("R8 dropped flag", cmd_dropped, 1);
    check("R8 wiper unchanged", wiper, 12);
    wait_ready();
    // R4: copy persistent to working
    issue(2'd2, 0);
    check("R4 copy to wiper", wiper, 5);
    // R5: copy working to persistent
    issue(2'd0, 17);
    issue(2'd3, 0);
    wait_ready();
    issue(2'd0, 3);
    issue(2'd2, 0);
    check("R5 stored working value", wiper, 17);
    // R9: soft reset keeps persistent copy
    step(1); rst_n = 1'b0; step(2); rst_n = 1'b1;
    check("R9 dropped cleared", cmd_dropped, 0);
    issue(2'd0, 9);
    check("R8 dropped during recall", cmd_dropped, 1);
    wait_ready();
    check("R9 soft reset recall", wiper, 17);
    // R10: soft reset aborts a store
    issue(2'd1, 9);
    step(5);
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    wait_ready();
    check("R10 aborted store", wiper, 17);
    // R7: completed store then soft reset
    issue(2'd1, 26);
    wait_ready();
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    wait_ready();
    check("R7 store committed", wiper, 26);
    // R9: cold reset clears persistent copy
    cold_rst_n = 1'b0; step(2); cold_rst_n = 1'b1;
    wait_ready();
    check("R9 cold reset clears", wiper, 0);
    step(3);
    finish_run();
  end
endmodule